// File: doc/BRIEF.md
# Linked-List Queue Push Engine

This block keeps a set of logical queues, each one a singly linked list of descriptor indices. Only the head and tail index of every queue lives inside the block. The per-descriptor "next" links are stored in an external linking memory, with one 32-bit word per descriptor. Because a list can always grow by one more link, a queue never fills up, and a push is accepted without any occupancy test.

A push names a queue and an index. The engine first writes a terminating link for the new descriptor. If the queue already holds entries, it then writes the new index into the old tail's link word. Finally it updates the tail register, and the head register as well when the queue was empty. A pop reads the link word of the current head, returns the head index and moves the head to the successor. When a queue is empty, a pop returns the null index straight away and does not touch memory.

The linking memory may be split over two regions. Two configuration inputs give the 32-bit-aligned byte base address of each region. A third input gives how many descriptors the first region holds. Indices below that count land in the first region. Every other index lands in the second region, offset by that count. The memory port uses word addresses and a request/acknowledge handshake, and the engine waits on every access until it is acknowledged.

Top module: `llq_push_engine`

## Requirements
- R1: After reset every queue is empty, `cmd_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0, so a pop of any queue returns 16'hFFFF.
- R2: The first memory access of every push is a write to the new index's link word, with data 32'h0000FFFF (null link in bits 15:0, zeros above).
- R3: A push to a non-empty queue performs a second write to the old tail's link word, with data equal to the new index zero-extended to 32 bits. A push to an empty queue performs no second write.
- R4: The word address of index i is cfg_base0[31:2] + i when i < cfg_size0, and cfg_base1[31:2] + (i - cfg_size0) otherwise.
- R5: A pop of a non-empty queue reads the head's link word and returns the indices in the order they were pushed.
- R6: A pop of an empty queue returns 16'hFFFF on `rsp_index` in the cycle after acceptance and makes no memory access.
- R7: A push is never refused for lack of space. Forty pushes onto one queue are all accepted and later popped back in order.
- R8: While `mem_req` is 1 and not yet acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold steady and `cmd_ready` is 0.
- R9: Queues are independent. Interleaved operations on different queues leave each queue's order intact.
- R10: `rsp_valid` is 1 for exactly one cycle per accepted pop and never as a result of a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base0 | input | 32 | Byte base address of the first linking region (32-bit aligned) |
| cfg_base1 | input | 32 | Byte base address of the second linking region (32-bit aligned) |
| cfg_size0 | input | 16 | Number of descriptors held by the first linking region |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; command accepted on valid and ready |
| cmd_op | input | 1 | 0 = push, 1 = pop |
| cmd_queue | input | 5 | Queue number |
| cmd_index | input | 16 | Descriptor index to push (ignored for pop) |
| rsp_valid | output | 1 | Pop result valid (one cycle) |
| rsp_index | output | 16 | Popped index, 16'hFFFF when the queue was empty |
| mem_req | output | 1 | Linking memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Linking memory word address |
| mem_wdata | output | 32 | Link word to write |
| mem_ack | input | 1 | Access done (one cycle) |
| mem_rdata | input | 32 | Link word read, valid with `mem_ack` |

## Verification
The list engine is driven with several patterns:
- A single queue filled with indices on both sides of the region split. This separates an address-mapping fault from a linking fault.
- Indices right at the boundary (size minus one, size itself, and the top index). These catch comparison and offset errors in the region mapping.
- Interleaved pushes and pops on the first and last queue. These expose cross-talk between pointer entries.
- A forty-deep list followed by a change of split point on emptied queues. This shows that lists neither saturate nor keep stale mapping.

Acknowledge delays vary from cycle to cycle, so every request must also survive a stall.

// File: rtl/llq_pkg.sv
package llq_pkg;
   typedef enum logic {
      LLQ_PUSH = 1'b0,
      LLQ_POP  = 1'b1
   } llq_op_e;

   typedef enum logic [1:0] {
      LLQ_IDLE    = 2'd0,
      LLQ_WR_NEW  = 2'd1,
      LLQ_WR_TAIL = 2'd2,
      LLQ_RD_HEAD = 2'd3
   } llq_state_e;

   localparam int LLQ_ENTRY_W = 32;
endpackage

// File: rtl/llq_addr_map.sv
module llq_addr_map #(
   parameter int IDX_W  = 16,
   parameter int ADDR_W = 32,
   localparam int WA_W  = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] base0,
   input  logic [ADDR_W-1:0] base1,
   input  logic [IDX_W-1:0]  size0,
   input  logic [IDX_W-1:0]  idx,
   output logic [WA_W-1:0]   waddr
);
   logic unused_low_bits;
   assign unused_low_bits = ^{base0[1:0], base1[1:0]};

   always_comb begin
      if (idx < size0) begin
         waddr = base0[ADDR_W-1:2] + WA_W'(idx);
      end else begin
         waddr = base1[ADDR_W-1:2] + WA_W'(idx - size0);
      end
   end
endmodule

// File: rtl/llq_ptr_table.sv
module llq_ptr_table #(
   parameter int QUEUES = 32,
   parameter int IDX_W  = 16,
   localparam int QW    = $clog2(QUEUES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [QW-1:0]    rd_q,
   output logic [IDX_W-1:0] rd_head,
   output logic [IDX_W-1:0] rd_tail,
   input  logic [QW-1:0]    wr_q,
   input  logic             head_we,
   input  logic [IDX_W-1:0] head_d,
   input  logic             tail_we,
   input  logic [IDX_W-1:0] tail_d
);
   logic [QUEUES-1:0][IDX_W-1:0] head_v;
   logic [QUEUES-1:0][IDX_W-1:0] tail_v;

   for (genvar g = 0; g < QUEUES; g++) begin : g_q
      logic [IDX_W-1:0] head_q;
      logic [IDX_W-1:0] tail_q;
      logic             sel;
      assign sel = (wr_q == QW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            head_q <= '1;
            tail_q <= '1;
         end else if (sel) begin
            if (head_we) head_q <= head_d;
            if (tail_we) tail_q <= tail_d;
         end
      end

      assign head_v[g] = head_q;
      assign tail_v[g] = tail_q;
   end

   assign rd_head = head_v[rd_q];
   assign rd_tail = tail_v[rd_q];
endmodule

// File: rtl/llq_ctrl.sv
module llq_ctrl
   import llq_pkg::*;
#(
   parameter int QUEUES = 32,
   parameter int IDX_W  = 16,
   parameter int WA_W   = 30,
   localparam int QW    = $clog2(QUEUES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic                   cmd_op,
   input  logic [QW-1:0]          cmd_queue,
   input  logic [IDX_W-1:0]       cmd_index,
   output logic                   rsp_valid,
   output logic [IDX_W-1:0]       rsp_index,
   output logic [QW-1:0]          rd_q,
   input  logic [IDX_W-1:0]       cur_head,
   input  logic [IDX_W-1:0]       cur_tail,
   output logic [QW-1:0]          wr_q,
   output logic                   head_we,
   output logic [IDX_W-1:0]       head_d,
   output logic                   tail_we,
   output logic [IDX_W-1:0]       tail_d,
   output logic [IDX_W-1:0]       map_idx,
   input  logic [WA_W-1:0]        map_addr,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [WA_W-1:0]        mem_addr,
   output logic [LLQ_ENTRY_W-1:0] mem_wdata,
   input  logic                   mem_ack,
   input  logic [LLQ_ENTRY_W-1:0] mem_rdata
);
   localparam logic [IDX_W-1:0] NULL_IDX = '1;

   llq_state_e       st;
   logic [QW-1:0]    lat_q;
   logic [IDX_W-1:0] lat_idx;
   logic [IDX_W-1:0] next_idx;
   logic             tail_null;
   logic             unused_rdata;

   assign next_idx     = mem_rdata[IDX_W-1:0];
   assign unused_rdata = ^mem_rdata[LLQ_ENTRY_W-1:IDX_W];
   assign tail_null    = (cur_tail == NULL_IDX);
   assign cmd_ready    = (st == LLQ_IDLE);
   assign rd_q         = (st == LLQ_IDLE) ? cmd_queue : lat_q;
   assign wr_q         = lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LLQ_IDLE;
         lat_q     <= '0;
         lat_idx   <= '0;
         rsp_valid <= 1'b0;
         rsp_index <= NULL_IDX;
      end else begin
         rsp_valid <= 1'b0;
         unique case (st)
            LLQ_IDLE: if (cmd_valid) begin
               lat_q   <= cmd_queue;
               lat_idx <= cmd_index;
               if (llq_op_e'(cmd_op) == LLQ_PUSH) begin
                  st <= LLQ_WR_NEW;
               end else if (cur_head == NULL_IDX) begin
                  rsp_valid <= 1'b1;
                  rsp_index <= NULL_IDX;
               end else begin
                  st <= LLQ_RD_HEAD;
               end
            end
            LLQ_WR_NEW: if (mem_ack) begin
               st <= tail_null ? LLQ_IDLE : LLQ_WR_TAIL;
            end
            LLQ_WR_TAIL: if (mem_ack) begin
               st <= LLQ_IDLE;
            end
            LLQ_RD_HEAD: if (mem_ack) begin
               rsp_valid <= 1'b1;
               rsp_index <= cur_head;
               st        <= LLQ_IDLE;
            end
            default: st <= LLQ_IDLE;
         endcase
      end
   end

   always_comb begin
      head_we = 1'b0;
      tail_we = 1'b0;
      head_d  = lat_idx;
      tail_d  = lat_idx;
      map_idx = cur_head;
      unique case (st)
         LLQ_WR_NEW: begin
            map_idx = lat_idx;
            head_we = mem_ack && tail_null;
            tail_we = mem_ack && tail_null;
         end
         LLQ_WR_TAIL: begin
            map_idx = cur_tail;
            tail_we = mem_ack;
         end
         LLQ_RD_HEAD: begin
            head_d  = next_idx;
            head_we = mem_ack;
            tail_d  = NULL_IDX;
            tail_we = mem_ack && (next_idx == NULL_IDX);
         end
         default: ;
      endcase
   end

   assign mem_req   = (st != LLQ_IDLE);
   assign mem_we    = (st != LLQ_RD_HEAD);
   assign mem_addr  = map_addr;
   assign mem_wdata = (st == LLQ_WR_NEW) ? {{(LLQ_ENTRY_W-IDX_W){1'b0}}, NULL_IDX}
                                         : {{(LLQ_ENTRY_W-IDX_W){1'b0}}, lat_idx};
endmodule

// File: rtl/llq_push_engine.sv
module llq_push_engine #(
   parameter int QUEUES = 32,
   parameter int IDX_W  = 16,
   parameter int ADDR_W = 32,
   localparam int QW    = $clog2(QUEUES),
   localparam int WA_W  = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base0,
   input  logic [ADDR_W-1:0] cfg_base1,
   input  logic [IDX_W-1:0]  cfg_size0,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_op,
   input  logic [QW-1:0]     cmd_queue,
   input  logic [IDX_W-1:0]  cmd_index,
   output logic              rsp_valid,
   output logic [IDX_W-1:0]  rsp_index,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WA_W-1:0]   mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   if (QUEUES < 2 || IDX_W < 2 || IDX_W >= 32 || ADDR_W < IDX_W + 2) begin : g_bad_params
      $error("llq_push_engine: unsupported parameter combination");
   end

   logic [QW-1:0]    rd_q, wr_q;
   logic [IDX_W-1:0] cur_head, cur_tail, head_d, tail_d, map_idx;
   logic             head_we, tail_we;
   logic [WA_W-1:0]  map_addr;

   llq_ptr_table #(.QUEUES(QUEUES), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .rd_q(rd_q), .rd_head(cur_head), .rd_tail(cur_tail),
      .wr_q(wr_q), .head_we(head_we), .head_d(head_d),
      .tail_we(tail_we), .tail_d(tail_d)
   );

   llq_addr_map #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_map (
      .base0(cfg_base0), .base1(cfg_base1), .size0(cfg_size0),
      .idx(map_idx), .waddr(map_addr)
   );

   llq_ctrl #(.QUEUES(QUEUES), .IDX_W(IDX_W), .WA_W(WA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_queue(cmd_queue), .cmd_index(cmd_index),
      .rsp_valid(rsp_valid), .rsp_index(rsp_index),
      .rd_q(rd_q), .cur_head(cur_head), .cur_tail(cur_tail),
      .wr_q(wr_q), .head_we(head_we), .head_d(head_d),
      .tail_we(tail_we), .tail_d(tail_d),
      .map_idx(map_idx), .map_addr(map_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );
endmodule

// File: rtl/llq_push_engine_chk.sv
module llq_push_engine_chk #(
   parameter int QUEUES = 32,
   parameter int IDX_W  = 16,
   parameter int ADDR_W = 32,
   localparam int WA_W  = ADDR_W - 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_base0,
   input logic [ADDR_W-1:0] cfg_base1,
   input logic [IDX_W-1:0]  cfg_size0,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_op,
   input logic [IDX_W-1:0]  cmd_index,
   input logic              rsp_valid,
   input logic [IDX_W-1:0]  rsp_index,
   input logic              mem_req,
   input logic              mem_we,
   input logic [WA_W-1:0]   mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ack
);
   localparam logic [31:0] NULL_WORD = {{(32-IDX_W){1'b0}}, {IDX_W{1'b1}}};

   logic unused_chk;
   assign unused_chk = ^{cfg_base0[1:0], cfg_base1[1:0], QUEUES[0]};

   // R1: the engine leaves reset idle with no memory request
   p_idle_at_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cmd_ready && !mem_req && !rsp_valid));

   // R2: a push always starts by terminating the new descriptor's link
   p_first_write_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_valid && cmd_ready && !cmd_op) |-> (mem_req && mem_we && mem_wdata == NULL_WORD));

   // R4: mapping into the first region
   p_map_first_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_valid && cmd_ready && !cmd_op) && $past(cmd_index) < cfg_size0)
      |-> (mem_addr == cfg_base0[ADDR_W-1:2] + WA_W'($past(cmd_index))));

   // R4: mapping into the second region
   p_map_second_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_valid && cmd_ready && !cmd_op) && $past(cmd_index) >= cfg_size0)
      |-> (mem_addr == cfg_base1[ADDR_W-1:2] + WA_W'($past(cmd_index) - cfg_size0)));

   // R6: an empty pop answers null without memory traffic
   p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_valid && cmd_ready && cmd_op) && rsp_valid) |-> (rsp_index == {IDX_W{1'b1}} && !mem_req));

   // R8: a pending request holds still
   p_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R8: no command accepted while memory is busy
   p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cmd_ready);

   // R10: a response only follows a pop acceptance or a completed read
   p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(cmd_valid && cmd_ready && cmd_op) || $past(mem_req && mem_ack && !mem_we)));
endmodule

bind llq_push_engine llq_push_engine_chk #(.QUEUES(QUEUES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/llq_push_engine_tb.sv
module llq_push_engine_tb_top;
   localparam int QN = 32;

   typedef struct packed {
      logic [29:0] addr;
      logic        we;
      logic [31:0] data;
   } mexp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] b0 = 32'h0000_1000;
   logic [31:0] b1 = 32'h0000_8000;
   logic [15:0] s0 = 16'd8;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_op = 1'b0;
   logic [4:0]  cmd_queue = '0;
   logic [15:0] cmd_index = '0;
   logic        rsp_valid;
   logic [15:0] rsp_index;
   logic        mem_req, mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #4 clk = ~clk;

   llq_push_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_base0(b0), .cfg_base1(b1), .cfg_size0(s0),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_queue(cmd_queue), .cmd_index(cmd_index),
      .rsp_valid(rsp_valid), .rsp_index(rsp_index),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int n_pops = 0;
   int n_rsp = 0;
   int cyc = 0;
   bit done = 1'b0;

   mexp_t       exp_mem[$];
   string       exp_mtag[$];
   logic [15:0] exp_rsp[$];
   string       exp_rtag[$];
   logic [15:0] model[QN][$];
   logic [31:0] lram[logic [29:0]];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
      end
   endtask

   function automatic logic [29:0] bmap(input logic [15:0] i);
      if (i < s0) return b0[31:2] + 30'(i);
      return b1[31:2] + 30'(i - s0);
   endfunction

   // linking memory model: acknowledge after a varying stall
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && !mem_ack && (cyc % 3) != 1) begin
         mem_ack   <= 1'b1;
         mem_rdata <= lram.exists(mem_addr) ? lram[mem_addr] : 32'hDEAD_BEEF;
         if (mem_we) lram[mem_addr] = mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // monitor: compares memory traffic and responses with the scoreboard
   bit          in_tx = 1'b0;
   logic [29:0] tx_addr;
   logic [31:0] tx_data;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && !in_tx) begin
            in_tx   = 1'b1;
            tx_addr = mem_addr;
            tx_data = mem_wdata;
         end
         if (mem_req && mem_ack) begin
            // R8: request held unchanged through the stall, command side blocked
            chk(mem_addr == tx_addr && mem_wdata == tx_data && !cmd_ready, "R8",
                "request changed during stall", {2'b0, mem_addr}, {2'b0, tx_addr});
            in_tx = 1'b0;
            if (exp_mem.size() == 0) begin
               chk(1'b0, "R6", "unexpected memory access", {2'b0, mem_addr}, 32'h0);
            end else begin
               mexp_t e;
               string t;
               e = exp_mem.pop_front();
               t = exp_mtag.pop_front();
               chk(mem_addr == e.addr && mem_we == e.we, t, "access address/direction",
                   {1'b0, mem_we, mem_addr}, {1'b0, e.we, e.addr});
               if (e.we) chk(mem_wdata == e.data, t, "link word data", mem_wdata, e.data);
            end
         end
         if (rsp_valid) begin
            n_rsp++;
            if (exp_rsp.size() == 0) begin
               chk(1'b0, "R10", "response without pop", {16'h0, rsp_index}, 32'h0);
            end else begin
               logic [15:0] ev;
               string t;
               ev = exp_rsp.pop_front();
               t  = exp_rtag.pop_front();
               chk(rsp_index == ev, t, "popped index", {16'h0, rsp_index}, {16'h0, ev});
            end
         end
      end
   end

   task automatic send(input bit op, input int q, input logic [15:0] i, input bit check_ready);
      int waited = 0;
      @(negedge clk);
      while (!cmd_ready) begin
         waited++;
         @(negedge clk);
      end
      // R7: the engine becomes ready again within a short bound; a push is never refused
      if (check_ready) chk(waited < 20, "R7", "push accepted", waited, 20);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_queue = 5'(q);
      cmd_index = i;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // R2 R3 R4: expected writes of a push
   task automatic push(input int q, input logic [15:0] i);
      exp_mem.push_back('{bmap(i), 1'b1, 32'h0000_FFFF});
      exp_mtag.push_back("R2/R4");
      if (model[q].size() > 0) begin
         exp_mem.push_back('{bmap(model[q][$]), 1'b1, {16'h0, i}});
         exp_mtag.push_back("R3/R4");
      end
      model[q].push_back(i);
      send(1'b0, q, i, 1'b1);
   endtask

   // R5 R6: expected result of a pop
   task automatic pop(input int q);
      n_pops++;
      if (model[q].size() == 0) begin
         exp_rsp.push_back(16'hFFFF);
         exp_rtag.push_back("R6");
      end else begin
         logic [15:0] h;
         h = model[q].pop_front();
         exp_mem.push_back('{bmap(h), 1'b0, 32'h0});
         exp_mtag.push_back("R5/R4");
         exp_rsp.push_back(h);
         exp_rtag.push_back("R5/R9");
      end
      send(1'b1, q, 16'h0, 1'b0);
   endtask

   task automatic drain();
      repeat (30) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state after reset
      chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", {31'h0, cmd_ready}, 32'h1);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
      // R1 R6: all queues start empty
      pop(0);
      pop(31);
      drain();

      // R4 R5: one queue crossing the region split
      push(3, 16'd2);
      push(3, 16'd5);
      push(3, 16'd9);
      pop(3); pop(3); pop(3); pop(3);
      drain();

      // R4: indices at the split point and the top index
      push(1, 16'd7);
      push(1, 16'd8);
      push(1, 16'hFFFE);
      push(1, 16'd0);
      pop(1); pop(1); pop(1); pop(1);
      drain();

      // R9: interleaved queues
      push(0, 16'd20);
      push(31, 16'd21);
      push(0, 16'd3);
      pop(31);
      push(31, 16'd4);
      pop(0);
      push(0, 16'd100);
      pop(31); pop(0); pop(31); pop(0); pop(0);
      drain();

      // R7: deep list, no fullness limit
      for (int k = 0; k < 40; k++) push(5, 16'(300 + 7 * k));
      for (int k = 0; k < 41; k++) pop(5);
      drain();

      // R4: new split and second base with all queues empty
      s0 = 16'd64;
      b1 = 32'h0002_0000;
      repeat (3) @(negedge clk);
      push(7, 16'd63);
      push(7, 16'd64);
      push(9, 16'd10);
      push(7, 16'd1000);
      pop(9); pop(7); pop(7); pop(7); pop(7);
      drain();

      // R10: one response per pop, no leftovers
      chk(n_rsp == n_pops, "R10", "response count", n_rsp, n_pops);
      chk(exp_mem.size() == 0, "R3", "missing memory accesses", exp_mem.size(), 0);
      chk(exp_rsp.size() == 0, "R5", "missing responses", exp_rsp.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog: run stalled, got %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule